// File: doc/BRIEF.md
# Top Pending Interrupt Reporter

This block answers reads of a read-only status word that names the single most urgent interrupt which is both pending and enabled for one privilege level, together with the priority it carries. It takes a 64-bit pending vector, a 64-bit enable vector and an 8-bit programmed priority for every source. It also takes a flag that says whether the advanced interrupt feature is present, a level select that says whether machine or supervisor state is being read, and a flag that says whether virtualization is active.

The selection is combinational from these inputs. The answer is captured into the response registers on the cycle a read strobe is seen. An access made while the feature is absent produces an illegal-access pulse instead of data. A supervisor-level read made while virtualization is active produces a redirect pulse, so that the virtual-supervisor copy answers it. Writes never change what the word reports.

Top module: `topi_reporter`

## Requirements
- R1: After a synchronous active-low reset, `rsp_data` is zero and `rsp_valid`, `rsp_illegal` and `rsp_redirect` are low. At most one of the three pulses is high in any cycle.
- R2: A read (`rd_en` high at a rising edge, feature present, no redirect) sets `rsp_valid` high for the next cycle. In that cycle `rsp_data` carries the winning identity in bits 27:16 and its reported priority in bits 7:0, and every other bit is zero. `rsp_data` is zero in every cycle where `rsp_valid` is low.
- R3: Only sources with both their pending bit and their enable bit set compete. Each competing source has a 9-bit urgency key, and the lowest key wins. The key is the programmed priority when that priority is nonzero, 0 when the priority is zero and the source's default rank is at or below the level threshold, and 256 when the priority is zero and the rank is above the threshold.
- R4: Equal keys are resolved by default rank: the source with the lower rank wins. The rank of identity i is (i*37) mod 64.
- R5: The reported priority is the programmed priority when it is nonzero. When it is zero, the reported priority is 255 if the source's rank is above the level threshold, and 0 otherwise.
- R6: Identity 0 never competes. When no source competes, a read returns the whole word as zero, with `rsp_valid` high.
- R7: With `feat_en` low, any read or write makes `rsp_illegal` high for the next cycle, with `rsp_valid` low and `rsp_data` zero.
- R8: A read with `lvl_sup` high and `virt_on` high makes `rsp_redirect` high for the next cycle, with `rsp_valid` low and `rsp_data` zero. A machine-level read made while `virt_on` is high is answered normally.
- R9: A write with the feature present raises none of the three pulses, and a read that follows returns the same word as before the write.
- R10: The threshold is 40 at machine level (`lvl_sup` low) and 24 at supervisor level (`lvl_sup` high). A zero-priority source of rank 37 therefore reports 0 at machine level and 255 at supervisor level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe for the status word |
| wr_en | input | 1 | Write strobe (data is ignored) |
| feat_en | input | 1 | Advanced interrupt feature present |
| lvl_sup | input | 1 | 0 selects machine level, 1 selects supervisor level |
| virt_on | input | 1 | Virtualization active |
| pend | input | 64 | Pending bit per source |
| enab | input | 64 | Enable bit per source |
| prio_flat | input | 512 | Programmed priority of source i in bits 8i+7:8i |
| rsp_data | output | 32 | Status word returned by a read |
| rsp_valid | output | 1 | Read answered this cycle |
| rsp_illegal | output | 1 | Access refused because the feature is absent |
| rsp_redirect | output | 1 | Supervisor read redirected to the virtual copy |

## Verification
The bench targets the zero-priority rule at both levels, using a rank-37 source. A design with the wrong threshold, or one that skips the 255 substitution, reports the wrong priority byte. It also checks that a zero-priority source below the threshold outranks a source programmed to 1, and that a tie is settled by rank and not by index. A design that ranks by index would name the other source in the identity field. Further cases cover a masked source, source 63, an empty set, and the feature-absent, redirect and write paths. A design that answered a redirected or refused access would show a nonzero word or a `rsp_valid` pulse.

// File: rtl/topi_pkg.sv
// Package: shared widths and the fixed default ranking of interrupt sources.
// Assumes 64 sources, so identities and ranks fit in 6 bits.
package topi_pkg;
    localparam int IDW   = 6;
    localparam int PRW   = 8;
    localparam int KEYW  = PRW + 1;

    // Default rank of a source; a lower value is more urgent. 37 is odd, so the map is a permutation.
    function automatic logic [IDW-1:0] dflt_rank(input logic [IDW-1:0] id);
        return IDW'(id * IDW'(37));
    endfunction
endpackage

// File: rtl/topi_key_gen.sv
// Module: topi_key_gen
// For each source, builds the 9-bit urgency key and the priority to report,
// taking the level threshold into account. Purely combinational.
module topi_key_gen
    import topi_pkg::*;
#(
    parameter int NSRC     = 64,
    parameter int THR_MACH = 40,
    parameter int THR_SUP  = 24
) (
    input  logic                   lvl_sup,
    input  logic [NSRC*PRW-1:0]    prio_flat,
    output logic [NSRC*KEYW-1:0]   key_flat,
    output logic [NSRC*PRW-1:0]    rep_flat
);
    localparam logic [IDW-1:0] THR_M = IDW'(THR_MACH);
    localparam logic [IDW-1:0] THR_S = IDW'(THR_SUP);

    logic [IDW-1:0] thr;
    // Choose the rank threshold for the level being read.
    always_comb thr = lvl_sup ? THR_S : THR_M;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [PRW-1:0] p;
        logic           late;
        assign p    = prio_flat[i*PRW +: PRW];
        assign late = dflt_rank(IDW'(i)) > thr;
        // Map the programmed priority to a selection key and a reported value.
        always_comb begin
            if (p != '0) begin
                key_flat[i*KEYW +: KEYW] = {1'b0, p};
                rep_flat[i*PRW +: PRW]   = p;
            end else if (late) begin
                key_flat[i*KEYW +: KEYW] = {1'b1, {PRW{1'b0}}};
                rep_flat[i*PRW +: PRW]   = {PRW{1'b1}};
            end else begin
                key_flat[i*KEYW +: KEYW] = '0;
                rep_flat[i*PRW +: PRW]   = '0;
            end
        end
    end
endmodule

// File: rtl/topi_arbiter.sv
// Module: topi_arbiter
// Chooses the competing source with the lowest key; equal keys go to the lower
// default rank. Source 0 never competes. Purely combinational.
module topi_arbiter
    import topi_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic [NSRC-1:0]        cand,
    input  logic [NSRC*KEYW-1:0]   key_flat,
    output logic                   found,
    output logic [IDW-1:0]         win_id
);
    logic [KEYW-1:0] best_key;
    logic [IDW-1:0]  best_rank;
    logic [KEYW-1:0] k;
    logic [IDW-1:0]  r;

    // Linear scan that keeps the best key and rank seen so far.
    always_comb begin
        found     = 1'b0;
        win_id    = '0;
        best_key  = '1;
        best_rank = '1;
        k         = '0;
        r         = '0;
        for (int i = 1; i < NSRC; i++) begin
            k = key_flat[i*KEYW +: KEYW];
            r = dflt_rank(IDW'(i));
            if (cand[i] && (!found || k < best_key ||
                            (k == best_key && r < best_rank))) begin
                found     = 1'b1;
                win_id    = IDW'(i);
                best_key  = k;
                best_rank = r;
            end
        end
    end
endmodule

// File: rtl/topi_access.sv
// Module: topi_access
// Access decoder and response register: decides whether an access is refused,
// redirected or answered, and captures the word for one cycle. Writes only
// matter when the feature is absent.
module topi_access #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic          feat_en,
    input  logic          lvl_sup,
    input  logic          virt_on,
    input  logic [DW-1:0] word,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_valid,
    output logic          rsp_illegal,
    output logic          rsp_redirect
);
    // Register a single-cycle response; a refused access takes precedence over a redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data     <= '0;
            rsp_valid    <= 1'b0;
            rsp_illegal  <= 1'b0;
            rsp_redirect <= 1'b0;
        end else begin
            rsp_data     <= '0;
            rsp_valid    <= 1'b0;
            rsp_illegal  <= 1'b0;
            rsp_redirect <= 1'b0;
            if ((rd_en || wr_en) && !feat_en) begin
                rsp_illegal <= 1'b1;
            end else if (rd_en && lvl_sup && virt_on) begin
                rsp_redirect <= 1'b1;
            end else if (rd_en) begin
                rsp_valid <= 1'b1;
                rsp_data  <= word;
            end
        end
    end
endmodule

// File: rtl/topi_reporter.sv
// Module: topi_reporter (top)
// Reports the most urgent pending-and-enabled interrupt as a packed word:
// identity in bits 27:16, priority in bits 7:0. Selection is combinational and
// captured on a read strobe. Assumes inputs are stable around the read edge.
module topi_reporter
    import topi_pkg::*;
#(
    parameter int NSRC     = 64,
    parameter int DW       = 32,
    parameter int ID_LSB   = 16,
    parameter int ID_W     = 12,
    parameter int THR_MACH = 40,
    parameter int THR_SUP  = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic                feat_en,
    input  logic                lvl_sup,
    input  logic                virt_on,
    input  logic [NSRC-1:0]     pend,
    input  logic [NSRC-1:0]     enab,
    input  logic [NSRC*PRW-1:0] prio_flat,
    output logic [DW-1:0]       rsp_data,
    output logic                rsp_valid,
    output logic                rsp_illegal,
    output logic                rsp_redirect
);
    logic [NSRC*KEYW-1:0] key_flat;
    logic [NSRC*PRW-1:0]  rep_flat;
    logic [NSRC-1:0]      cand;
    logic                 found;
    logic [IDW-1:0]       win_id;
    logic [DW-1:0]        word;

    // Only pending and enabled sources compete.
    always_comb cand = pend & enab;

    topi_key_gen #(.NSRC(NSRC), .THR_MACH(THR_MACH), .THR_SUP(THR_SUP)) u_key (
        .lvl_sup  (lvl_sup),
        .prio_flat(prio_flat),
        .key_flat (key_flat),
        .rep_flat (rep_flat)
    );

    topi_arbiter #(.NSRC(NSRC)) u_arb (
        .cand    (cand),
        .key_flat(key_flat),
        .found   (found),
        .win_id  (win_id)
    );

    // Pack identity and priority; an empty result is an all-zero word.
    always_comb begin
        word = '0;
        if (found) begin
            word[ID_LSB +: ID_W] = ID_W'(win_id);
            word[PRW-1:0]        = rep_flat[win_id*PRW +: PRW];
        end
    end

    topi_access #(.DW(DW)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .feat_en     (feat_en),
        .lvl_sup     (lvl_sup),
        .virt_on     (virt_on),
        .word        (word),
        .rsp_data    (rsp_data),
        .rsp_valid   (rsp_valid),
        .rsp_illegal (rsp_illegal),
        .rsp_redirect(rsp_redirect)
    );
endmodule

// File: rtl/topi_reporter_chk.sv
// Module: topi_reporter_chk
// Port-level protocol checks for topi_reporter, attached with bind.
module topi_reporter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_en,
    input logic        wr_en,
    input logic        feat_en,
    input logic        lvl_sup,
    input logic        virt_on,
    input logic [31:0] rsp_data,
    input logic        rsp_valid,
    input logic        rsp_illegal,
    input logic        rsp_redirect
);
    // R1
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, rsp_illegal, rsp_redirect}));
    // R2
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_data == 32'd0);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_data[31:28] == 4'd0 && rsp_data[15:8] == 8'd0);
    // R7
    illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!feat_en && (rd_en || wr_en)) |=> rsp_illegal);
    // R8
    redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_redirect |-> $past(rd_en && lvl_sup && virt_on && feat_en));
    // R9
    write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && feat_en) |=> !(rsp_valid || rsp_illegal || rsp_redirect));
endmodule

bind topi_reporter topi_reporter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .feat_en(feat_en),
    .lvl_sup(lvl_sup), .virt_on(virt_on), .rsp_data(rsp_data),
    .rsp_valid(rsp_valid), .rsp_illegal(rsp_illegal), .rsp_redirect(rsp_redirect)
);

// File: tb/tb_topi_reporter.sv
// Bench for topi_reporter: a table of vectors checked against a reference
// scan, then directed corner cases.
module tb_topi_reporter;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    // Vector fields: {level, pend[63:0], enab[63:0], priority seed[7:0]}
    localparam logic [136:0] VEC [NV] = '{
        {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3},
        {1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd3},
        {1'b0, 64'hA5A5_0F0F_3C3C_9696, 64'hFF00_FF00_FF00_FF00, 8'd11},
        {1'b1, 64'h1234_5678_9ABC_DEF0, 64'h0FF0_0FF0_F00F_F00F, 8'd29},
        {1'b0, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 8'd5},
        {1'b1, 64'h0000_0000_0000_00FE, 64'h0000_0000_0000_00FE, 8'd0},
        {1'b0, 64'hDEAD_BEEF_CAFE_F00D, 64'h5555_AAAA_5555_AAAA, 8'd77},
        {1'b1, 64'h0000_0001_0000_0000, 64'h0000_0000_FFFF_FFFF, 8'd9}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_en = 1'b0, wr_en = 1'b0, feat_en = 1'b1;
    logic         lvl_sup = 1'b0, virt_on = 1'b0;
    logic [63:0]  pend = '0, enab = '0;
    logic [7:0]   pr [64];
    logic [511:0] prio_flat;
    logic [31:0]  rsp_data;
    logic         rsp_valid, rsp_illegal, rsp_redirect;
    int           total = 0, bad = 0;
    logic [31:0]  held;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack the bench's priority array onto the port.
    always_comb for (int i = 0; i < 64; i++) prio_flat[i*8 +: 8] = pr[i];

    topi_reporter dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .feat_en(feat_en),
        .lvl_sup(lvl_sup), .virt_on(virt_on), .pend(pend), .enab(enab),
        .prio_flat(prio_flat), .rsp_data(rsp_data), .rsp_valid(rsp_valid),
        .rsp_illegal(rsp_illegal), .rsp_redirect(rsp_redirect)
    );

    // Fails the run if it does not finish in time.
    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference from the requirements: rank = (i*37)%64, thresholds 40 and 24.
    function automatic logic [31:0] ref_word(input logic lvl);
        int thr = lvl ? 24 : 40;
        int best = -1, bkey = 0, brank = 0, brep = 0;
        for (int i = 1; i < 64; i++) begin
            int rk = (i * 37) % 64;
            int key, rep;
            if (!(pend[i] && enab[i])) continue;
            if (pr[i] != 0) begin key = pr[i]; rep = pr[i]; end
            else if (rk > thr) begin key = 256; rep = 255; end
            else begin key = 0; rep = 0; end
            if (best < 0 || key < bkey || (key == bkey && rk < brank)) begin
                best = i; bkey = key; brank = rk; brep = rep;
            end
        end
        if (best < 0) return 32'd0;
        return (32'(best) << 16) | 32'(brep);
    endfunction

    task automatic do_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic do_write();
        @(negedge clk); wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic clear_prio();
        for (int i = 0; i < 64; i++) pr[i] = 8'd0;
    endtask

    initial begin
        clear_prio();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset data", rsp_data, 32'd0);
        check("R1 reset flags", {29'd0, rsp_valid, rsp_illegal, rsp_redirect}, 32'd0);
        rst_n = 1'b1;

        // R2 R3 R4 R5: table walk against the reference scan
        for (int v = 0; v < NV; v++) begin
            lvl_sup = VEC[v][136];
            pend    = VEC[v][135:72];
            enab    = VEC[v][71:8];
            for (int i = 0; i < 64; i++)
                pr[i] = ((i + int'(VEC[v][7:0])) % 5 == 0) ? 8'd0
                        : 8'((i * int'(VEC[v][7:0]) * 7 + 13) % 256);
            do_read();
            check("R3 table word", rsp_data, ref_word(lvl_sup));
            check("R2 table valid", {31'd0, rsp_valid}, 32'd1);
        end

        // R4: tie at priority 10 between 5 (rank 57) and 9 (rank 13)
        clear_prio(); lvl_sup = 1'b0; enab = '1;
        pend = 64'h0; pend[5] = 1'b1; pend[9] = 1'b1; pr[5] = 8'd10; pr[9] = 8'd10;
        do_read();
        check("R4 tie by rank", rsp_data, 32'h0009_000A);

        // R10 R5: source 1 (rank 37) at priority zero, machine then supervisor
        clear_prio(); pend = 64'h2;
        do_read();
        check("R10 machine zero prio", rsp_data, 32'h0001_0000);
        lvl_sup = 1'b1;
        do_read();
        check("R10 supervisor zero prio", rsp_data, 32'h0001_00FF);

        // R5: source 3 (rank 47) at priority zero reports 255 at machine level
        lvl_sup = 1'b0; pend = 64'h8;
        do_read();
        check("R5 late rank zero prio", rsp_data, 32'h0003_00FF);

        // R3: zero-priority early-rank source 1 beats source 2 programmed to 1
        pend = 64'h6; pr[2] = 8'd1;
        do_read();
        check("R3 zero key wins", rsp_data, 32'h0001_0000);

        // R3: masked source does not compete
        enab = ~64'h2;
        do_read();
        check("R3 enable mask", rsp_data, 32'h0002_0001);

        // R6: boundary source 63, then empty set, then source 0 alone
        clear_prio(); enab = '1; pend = 64'h8000_0000_0000_0000; pr[63] = 8'd200;
        do_read();
        check("R6 source 63", rsp_data, 32'h003F_00C8);
        pend = 64'h0;
        do_read();
        check("R6 empty word", rsp_data, 32'd0);
        check("R6 empty valid", {31'd0, rsp_valid}, 32'd1);
        pend = 64'h1; pr[0] = 8'd5;
        do_read();
        check("R6 source 0 ignored", rsp_data, 32'd0);

        // R7: feature absent, read then write
        pend = 64'h8000_0000_0000_0000; feat_en = 1'b0;
        do_read();
        check("R7 read illegal", {29'd0, rsp_valid, rsp_illegal, rsp_data[0] | (|rsp_data)}, 32'h2);
        do_write();
        check("R7 write illegal", {31'd0, rsp_illegal}, 32'd1);
        feat_en = 1'b1;

        // R8: redirect at supervisor level, machine level answered
        virt_on = 1'b1; lvl_sup = 1'b1;
        do_read();
        check("R8 redirect", {29'd0, rsp_valid, rsp_redirect, |rsp_data}, 32'h2);
        lvl_sup = 1'b0;
        do_read();
        check("R8 machine with virt", rsp_data, 32'h003F_00C8);
        virt_on = 1'b0;

        // R9: write has no effect
        do_read(); held = rsp_data;
        do_write();
        check("R9 write silent", {29'd0, rsp_valid, rsp_illegal, rsp_redirect}, 32'd0);
        do_read();
        check("R9 word unchanged", rsp_data, held);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule